// File: doc/BRIEF.md
# Tag-Renamed Register File

This block is the architectural register file of an out-of-order core that schedules work through reservation stations. Every register holds either a settled value or the tag of the station that will eventually produce its value. When an instruction issues, its two source addresses are looked up. Each lookup returns either a ready value or the tag the operand must wait for. In the same cycle, the destination register is renamed to the tag of the station that was allocated for the instruction.

Results come back over a shared broadcast bus that carries a producer tag and a data word. Every register waiting on that tag captures the data and becomes settled. The reservation stations watch the same bus, so the file and the waiting operands update in the same cycle. A lookup that meets a matching broadcast in the same cycle is bypassed, so the consumer sees the data without waiting a cycle. Renaming by tag removes write-after-read and write-after-write hazards between instructions in flight. Only the newest rename of a register can settle it.

Top module: `tag_rename_regfile`

## Requirements
- R1: After reset every register is settled with value 0. A lookup of any address returns ready=1, tag=0, data=0.
- R2: A lookup of a settled register, with no matching broadcast, returns ready=1, tag=0 and the stored value, combinationally in the same cycle.
- R3: An issue with a nonzero destination tag makes the destination pending from the next cycle. A lookup then returns ready=0, data=0 and the tag that was issued.
- R4: A broadcast whose tag matches a pending register's tag writes the broadcast data into that register and settles it from the next cycle.
- R5: When a lookup addresses a pending register whose tag matches a broadcast in the same cycle, it returns ready=1, tag=0 and the broadcast data in that cycle (bypass).
- R6: A second rename of a register replaces the older tag. A later broadcast of the older tag leaves the register pending with the newer tag, and a lookup does not bypass it.
- R7: If an issue renames a register in the same cycle that a broadcast would settle it, the register stays pending with the newly issued tag.
- R8: Tag value 0 means "no producer". A broadcast with tag 0 changes no register. An issue with destination tag 0 renames nothing.
- R9: Lookups in an issue cycle see the state before that cycle's rename. This still holds when a source address equals the destination address.
- R10: One broadcast settles every register that is waiting on its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction issues this cycle |
| dst_addr_i | input | ADDR_W | Destination register to rename |
| dst_tag_i | input | TAG_W | Tag of the allocated station (0 means no destination) |
| src_a_addr_i | input | ADDR_W | First source lookup address |
| src_b_addr_i | input | ADDR_W | Second source lookup address |
| src_a_ready_o | output | 1 | First operand value is available |
| src_a_tag_o | output | TAG_W | Producer tag of the first operand when not ready, else 0 |
| src_a_data_o | output | DATA_W | First operand value when ready, else 0 |
| src_b_ready_o | output | 1 | Second operand value is available |
| src_b_tag_o | output | TAG_W | Producer tag of the second operand when not ready, else 0 |
| src_b_data_o | output | DATA_W | Second operand value when ready, else 0 |
| cdb_valid_i | input | 1 | A result is broadcast this cycle |
| cdb_tag_i | input | TAG_W | Tag of the producing station |
| cdb_data_i | input | DATA_W | Result data |

## Verification
The hardest case to reach is a collision on one register: a broadcast of its current tag arrives in the same cycle as a new issue that renames it. A close relative is a broadcast of a tag that has already been replaced. Both need a register renamed twice while the first producer is still outstanding. The stimulus renames a register, then drives a broadcast of that tag together with a second rename in one cycle. It samples the bypassed lookup in that cycle and the pending lookup in the next. A separate sequence renames a register twice before broadcasting the stale tag, and then the live tag.

// File: rtl/trf_pkg.sv
package trf_pkg;
  localparam int DEF_REGS   = 16;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_TAG_W  = 4;

  typedef enum logic [1:0] {
    SRC_FILE    = 2'd0,
    SRC_BYPASS  = 2'd1,
    SRC_PENDING = 2'd2
  } src_sel_e;
endpackage

// File: rtl/trf_entry.sv
module trf_entry #(
  parameter int DATA_W = trf_pkg::DEF_DATA_W,
  parameter int TAG_W  = trf_pkg::DEF_TAG_W,
  parameter int ADDR_W = 4,
  parameter int IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [TAG_W-1:0]  dst_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              busy_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] value_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

  logic              busy_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] value_q;
  logic              rename;

  assign rename = issue_valid_i && (dst_tag_i != '0) && (dst_addr_i == MY_ADDR);
  assign hit_o  = cdb_valid_i && (cdb_tag_i != '0) && busy_q && (tag_q == cdb_tag_i);

  // rename has priority over a same-cycle capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tag_q   <= '0;
      value_q <= '0;
    end else if (rename) begin
      busy_q <= 1'b1;
      tag_q  <= dst_tag_i;
    end else if (hit_o) begin
      busy_q  <= 1'b0;
      tag_q   <= '0;
      value_q <= cdb_data_i;
    end
  end

  assign busy_o  = busy_q;
  assign tag_o   = tag_q;
  assign value_o = value_q;
endmodule

// File: rtl/trf_read_port.sv
module trf_read_port #(
  parameter int NUM_REGS = trf_pkg::DEF_REGS,
  parameter int DATA_W   = trf_pkg::DEF_DATA_W,
  parameter int TAG_W    = trf_pkg::DEF_TAG_W,
  parameter int ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_REGS-1:0] busy_i,
  input  logic [NUM_REGS-1:0] hit_i,
  input  logic [TAG_W-1:0]    tag_i   [NUM_REGS],
  input  logic [DATA_W-1:0]   value_i [NUM_REGS],
  input  logic [DATA_W-1:0]   cdb_data_i,
  output logic                ready_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [DATA_W-1:0]   data_o
);
  import trf_pkg::*;

  src_sel_e sel;

  always_comb begin
    if (!busy_i[addr_i])    sel = SRC_FILE;
    else if (hit_i[addr_i]) sel = SRC_BYPASS;
    else                    sel = SRC_PENDING;
  end

  always_comb begin
    ready_o = 1'b1;
    tag_o   = '0;
    data_o  = '0;
    unique case (sel)
      SRC_FILE:    data_o  = value_i[addr_i];
      SRC_BYPASS:  data_o  = cdb_data_i;
      SRC_PENDING: begin
        ready_o = 1'b0;
        tag_o   = tag_i[addr_i];
      end
      default:     ready_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tag_rename_regfile.sv
module tag_rename_regfile #(
  parameter int NUM_REGS = trf_pkg::DEF_REGS,
  parameter int DATA_W   = trf_pkg::DEF_DATA_W,
  parameter int TAG_W    = trf_pkg::DEF_TAG_W,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [TAG_W-1:0]  dst_tag_i,
  input  logic [ADDR_W-1:0] src_a_addr_i,
  input  logic [ADDR_W-1:0] src_b_addr_i,
  output logic              src_a_ready_o,
  output logic [TAG_W-1:0]  src_a_tag_o,
  output logic [DATA_W-1:0] src_a_data_o,
  output logic              src_b_ready_o,
  output logic [TAG_W-1:0]  src_b_tag_o,
  output logic [DATA_W-1:0] src_b_data_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i
);
  logic [NUM_REGS-1:0] busy_vec;
  logic [NUM_REGS-1:0] hit_vec;
  logic [TAG_W-1:0]    tag_arr [NUM_REGS];
  logic [DATA_W-1:0]   val_arr [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    trf_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .IDX(k)
    ) u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .issue_valid_i(issue_valid_i),
      .dst_addr_i   (dst_addr_i),
      .dst_tag_i    (dst_tag_i),
      .cdb_valid_i  (cdb_valid_i),
      .cdb_tag_i    (cdb_tag_i),
      .cdb_data_i   (cdb_data_i),
      .busy_o       (busy_vec[k]),
      .tag_o        (tag_arr[k]),
      .value_o      (val_arr[k]),
      .hit_o        (hit_vec[k])
    );
  end

  trf_read_port #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_rd_a (
    .addr_i    (src_a_addr_i),
    .busy_i    (busy_vec),
    .hit_i     (hit_vec),
    .tag_i     (tag_arr),
    .value_i   (val_arr),
    .cdb_data_i(cdb_data_i),
    .ready_o   (src_a_ready_o),
    .tag_o     (src_a_tag_o),
    .data_o    (src_a_data_o)
  );

  trf_read_port #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_rd_b (
    .addr_i    (src_b_addr_i),
    .busy_i    (busy_vec),
    .hit_i     (hit_vec),
    .tag_i     (tag_arr),
    .value_i   (val_arr),
    .cdb_data_i(cdb_data_i),
    .ready_o   (src_b_ready_o),
    .tag_o     (src_b_tag_o),
    .data_o    (src_b_data_o)
  );
endmodule

// File: rtl/trf_checker.sv
module trf_checker #(
  parameter int NUM_REGS = trf_pkg::DEF_REGS,
  parameter int DATA_W   = trf_pkg::DEF_DATA_W,
  parameter int TAG_W    = trf_pkg::DEF_TAG_W,
  parameter int ADDR_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                issue_valid_i,
  input logic [ADDR_W-1:0]   dst_addr_i,
  input logic [TAG_W-1:0]    dst_tag_i,
  input logic [ADDR_W-1:0]   src_a_addr_i,
  input logic                src_a_ready_o,
  input logic [TAG_W-1:0]    src_a_tag_o,
  input logic [DATA_W-1:0]   src_a_data_o,
  input logic                cdb_valid_i,
  input logic [TAG_W-1:0]    cdb_tag_i,
  input logic [DATA_W-1:0]   cdb_data_i,
  input logic [NUM_REGS-1:0] busy_vec,
  input logic [TAG_W-1:0]    tag_arr [NUM_REGS],
  input logic [DATA_W-1:0]   val_arr [NUM_REGS]
);
  logic live_issue, live_cdb;
  assign live_issue = issue_valid_i && (dst_tag_i != '0);
  assign live_cdb   = cdb_valid_i && (cdb_tag_i != '0);

  p_settled_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_vec[src_a_addr_i] |->
      src_a_ready_o && (src_a_tag_o == '0) && (src_a_data_o == val_arr[src_a_addr_i]));

  p_rename_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_issue |=> busy_vec[$past(dst_addr_i)] && (tag_arr[$past(dst_addr_i)] == $past(dst_tag_i)));

  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cdb && busy_vec[src_a_addr_i] && (tag_arr[src_a_addr_i] == cdb_tag_i)) |->
      src_a_ready_o && (src_a_data_o == cdb_data_i));

  p_no_spurious_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_issue |=> ((busy_vec & ~$past(busy_vec)) == '0));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    logic rn, hit;
    assign rn  = live_issue && (dst_addr_i == ADDR_W'(k));
    assign hit = live_cdb && busy_vec[k] && (tag_arr[k] == cdb_tag_i);

    p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !rn) |=> !busy_vec[k] && (val_arr[k] == $past(cdb_data_i)));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_vec[k] && !hit && !rn) |=> busy_vec[k] && $stable(tag_arr[k]));
  end
endmodule

bind tag_rename_regfile trf_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .dst_addr_i   (dst_addr_i),
  .dst_tag_i    (dst_tag_i),
  .src_a_addr_i (src_a_addr_i),
  .src_a_ready_o(src_a_ready_o),
  .src_a_tag_o  (src_a_tag_o),
  .src_a_data_o (src_a_data_o),
  .cdb_valid_i  (cdb_valid_i),
  .cdb_tag_i    (cdb_tag_i),
  .cdb_data_i   (cdb_data_i),
  .busy_vec     (busy_vec),
  .tag_arr      (tag_arr),
  .val_arr      (val_arr)
);

// File: tb/sim_tag_rename_regfile.sv
module sim_tag_rename_regfile;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int AW = 4;

  typedef struct {
    string       req;
    bit          port_b;
    bit          ready;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_valid = 1'b0;
  logic [AW-1:0] dst_addr = '0, a_addr = '0, b_addr = '0;
  logic [TW-1:0] dst_tag = '0, cdb_tag = '0;
  logic cdb_valid = 1'b0;
  logic [DW-1:0] cdb_data = '0;
  logic a_rdy, b_rdy;
  logic [TW-1:0] a_tag, b_tag;
  logic [DW-1:0] a_dat, b_dat;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  tag_rename_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .dst_addr_i(dst_addr), .dst_tag_i(dst_tag),
    .src_a_addr_i(a_addr), .src_b_addr_i(b_addr),
    .src_a_ready_o(a_rdy), .src_a_tag_o(a_tag), .src_a_data_o(a_dat),
    .src_b_ready_o(b_rdy), .src_b_tag_o(b_tag), .src_b_data_o(b_dat),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic r; logic [TW-1:0] t; logic [DW-1:0] d;
      e = sb.pop_front();
      r = e.port_b ? b_rdy : a_rdy;
      t = e.port_b ? b_tag : a_tag;
      d = e.port_b ? b_dat : a_dat;
      total++;
      if (r !== e.ready || t !== e.tag || d !== e.data) begin
        bad++;
        $display("FAIL %s port%s: got rdy=%0b tag=%0d data=%h exp rdy=%0b tag=%0d data=%h",
                 e.req, e.port_b ? "B" : "A", r, t, d, e.ready, e.tag, e.data);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    issue_valid = 1'b0; cdb_valid = 1'b0;
  endtask

  task automatic expect_src(string req, bit pb, bit rdy, logic [TW-1:0] t, logic [DW-1:0] d);
    exp_t e;
    e.req = req; e.port_b = pb; e.ready = rdy; e.tag = t; e.data = d;
    sb.push_back(e);
  endtask

  task automatic issue(logic [AW-1:0] a, logic [TW-1:0] t);
    issue_valid = 1'b1; dst_addr = a; dst_tag = t;
  endtask

  task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] d);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step();
    a_addr = 0; b_addr = 5;
    expect_src("R1", 0, 1, 0, 0); expect_src("R1", 1, 1, 0, 0);
    step();
    // rename r3 to tag 5, read r3 in the same cycle
    issue(3, 5); a_addr = 3;
    expect_src("R9", 0, 1, 0, 0);
    step();
    expect_src("R3", 0, 0, 5, 0);
    step();
    bcast(5, 32'hAAAA_0001);
    expect_src("R5", 0, 1, 0, 32'hAAAA_0001);
    step();
    expect_src("R4", 0, 1, 0, 32'hAAAA_0001);
    step();
    // double rename of r7, stale broadcast
    issue(7, 2); step();
    issue(7, 9); step();
    bcast(2, 32'h1111_1111); b_addr = 7;
    expect_src("R6", 1, 0, 9, 0);
    step();
    expect_src("R6", 1, 0, 9, 0);
    step();
    bcast(9, 32'h2222_2222);
    step();
    expect_src("R6", 1, 1, 0, 32'h2222_2222);
    step();
    // collision: rename and settling broadcast on r4 together
    issue(4, 6); step();
    issue(4, 11); bcast(6, 32'h3333_3333); a_addr = 4;
    expect_src("R5", 0, 1, 0, 32'h3333_3333);
    step();
    expect_src("R7", 0, 0, 11, 0);
    step();
    bcast(11, 32'h4444_4444);
    step();
    expect_src("R7", 0, 1, 0, 32'h4444_4444);
    step();
    // tag 0 traffic
    bcast(0, 32'hFFFF_FFFF); a_addr = 0;
    expect_src("R8", 0, 1, 0, 0);
    step();
    expect_src("R8", 0, 1, 0, 0);
    issue(2, 0); b_addr = 2;
    step();
    expect_src("R8", 1, 1, 0, 0);
    step();
    // two registers waiting on one tag
    issue(8, 12); step();
    issue(9, 12); step();
    bcast(12, 32'h5555_5555);
    step();
    a_addr = 8; b_addr = 9;
    expect_src("R10", 0, 1, 0, 32'h5555_5555);
    expect_src("R10", 1, 1, 0, 32'h5555_5555);
    step();
    a_addr = 3;
    expect_src("R2", 0, 1, 0, 32'hAAAA_0001);
    step();
    step();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hung exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule